// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block is the fetch side of a packet transmitter. It walks a ring of descriptors held in a word-addressed memory. Each descriptor is four consecutive 32-bit words. The host marks a descriptor as ready by setting its ownership bit. The engine then reads the descriptor, streams the buffer it names out as bytes, and writes back a completion status that hands the descriptor back to the host.

The host controls the engine with a run level and a poll-demand write. While run is low the engine sits stopped with its ring pointer parked on the ring base. When run goes high the engine moves to a suspended state. A poll-demand write carrying the wake code starts a pass. The pass continues descriptor by descriptor until the engine meets one it does not own.

A descriptor flagged as a setup frame is read in full but is consumed internally; none of its bytes reach the stream. Framing, CRC, chained descriptors and arbitration for the memory are left to neighbouring blocks. The memory interface is a single request port: a read returns its data one cycle after the request, and a write completes in the request cycle.

Top module: `txr_engine`

## Requirements
- R1: After reset the engine is stopped: `idle` is 1, and both `mem_req` and `out_valid` are 0.
- R2: The engine leaves the suspended state only on a `poll_wr` pulse whose `poll_data` equals 1 while `tx_run` is 1. A poll carrying any other value issues no memory request, and so does any poll while `tx_run` is 0.
- R3: Bit 31 of the first descriptor word (status) is ownership. If it reads 0, the engine makes no further reads or writes for that descriptor, emits no byte, and suspends.
- R4: The control word (word 1) has these fields:
  - bits 10:0 give the byte length;
  - bit 29 marks the first segment;
  - bit 30 marks the last segment.

  Word 2 is the buffer byte address; its low two bits are ignored. The engine emits exactly length bytes, in little-endian order from each buffer word. `out_first` is set on the first byte only when bit 29 is set, and `out_last` is set on the final byte only when bit 30 is set.
- R5: When a normal descriptor with a length of 1 or more completes, 32'h0000_0000 is written to its status word, which clears ownership.
- R6: A normal descriptor with a length of 0 reads no buffer word, emits nothing, and gets the status 32'h0000_8000 (bit 15 is the error summary).
- R7: A descriptor with bit 27 of its control word set is a setup frame, and it never drives bytes out. With a length of 192 it reads all 48 buffer words and gets the status 32'h7FFF_FFFF. With any other length it reads no buffer word and gets 32'h0000_8000.
- R8: After a write-back the engine goes straight on to the next descriptor without a new poll. The next descriptor is the ring base when bit 25 (end of ring) of the control word is set, and otherwise the current descriptor plus four words.
- R9: If `tx_run` is low when a write-back completes, the engine stops after finishing that descriptor. While stopped, the ring pointer reloads from `ring_base`, so a restart begins at the base.
- R10: A valid poll that arrives while a pass is under way is remembered. This includes a poll in the very cycle a not-owned status word is returned. In that case the engine reads the same status word again instead of suspending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ring_base | input | ADDR_W-2 | Word address of descriptor 0 |
| tx_run | input | 1 | Transmit enable level |
| poll_wr | input | 1 | Poll-demand write strobe |
| poll_data | input | 32 | Value written with the poll strobe |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable (with `mem_req`) |
| mem_addr | output | ADDR_W-2 | Memory word address |
| mem_wdata | output | 32 | Write data (completion status) |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| out_valid | output | 1 | Byte stream valid |
| out_data | output | 8 | Byte stream data |
| out_first | output | 1 | First byte of a first segment |
| out_last | output | 1 | Final byte of a last segment |
| idle | output | 1 | Engine stopped or suspended |

## Verification
Two things can land in the same cycle: a poll-demand write from the host, and the engine's finding that the descriptor is still host-owned. If the poll is lost, a frame the host has just handed over is left unsent until some later poll. The bench provokes this race. It waits for the status-word read request. In the next cycle, while that stale not-owned word is being returned, it sets the ownership bit in memory and pulses the poll. The race is judged at the ports: the frame's bytes must appear on the stream and the descriptor's status must be written back to zero.

// File: rtl/txr_pkg.sv
package txr_pkg;

    localparam int LEN_W       = 11;
    localparam int OWN_BIT     = 31;
    localparam int LAST_BIT    = 30;
    localparam int FIRST_BIT   = 29;
    localparam int SETUP_BIT   = 27;
    localparam int EOR_BIT     = 25;
    localparam int DESC_WORDS  = 4;
    localparam int SETUP_LEN   = 192;
    localparam logic [31:0] POLL_CODE  = 32'd1;
    localparam logic [31:0] ST_ERR     = 32'h0000_8000;
    localparam logic [31:0] ST_SETUPOK = 32'h7FFF_FFFF;
    localparam logic [31:0] ST_DONE    = 32'h0000_0000;

    typedef enum logic [3:0] {
        S_STOP,
        S_SUSP,
        S_SREQ,
        S_SCAP,
        S_CREQ,
        S_CCAP,
        S_BREQ,
        S_BCAP,
        S_DREQ,
        S_DCAP,
        S_EMIT,
        S_WB
    } txr_state_e;

    typedef struct packed {
        logic             eor;
        logic             last_seg;
        logic             first_seg;
        logic             setup;
        logic [LEN_W-1:0] len;
    } txr_ctrl_t;

endpackage

// File: rtl/txr_ctrl_decode.sv
module txr_ctrl_decode
    import txr_pkg::*;
(
    input  txr_ctrl_t   ctrl,
    output logic        len_ok,
    output logic [31:0] wb_status
);

    always_comb begin
        if (ctrl.setup) begin
            len_ok = (ctrl.len == LEN_W'(SETUP_LEN));
        end else begin
            len_ok = (ctrl.len != '0);
        end

        if (!len_ok) begin
            wb_status = ST_ERR;
        end else if (ctrl.setup) begin
            wb_status = ST_SETUPOK;
        end else begin
            wb_status = ST_DONE;
        end
    end

endmodule

// File: rtl/txr_next_addr.sv
module txr_next_addr
    import txr_pkg::*;
#(
    parameter int WA_W = 14
) (
    input  logic [WA_W-1:0] cur,
    input  logic [WA_W-1:0] base,
    input  logic            eor,
    output logic [WA_W-1:0] nxt
);

    always_comb begin
        if (eor) begin
            nxt = base;
        end else begin
            nxt = cur + WA_W'(DESC_WORDS);
        end
    end

endmodule

// File: rtl/txr_lane_mux.sv
module txr_lane_mux #(
    parameter  int WORD_W = 32,
    parameter  int LANE_W = 8,
    localparam int LANES  = WORD_W / LANE_W,
    localparam int SEL_W  = $clog2(LANES)
) (
    input  logic [WORD_W-1:0] word,
    input  logic [SEL_W-1:0]  sel,
    output logic [LANE_W-1:0] lane
);

    logic [LANE_W-1:0] lanes [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes[g] = word[g*LANE_W +: LANE_W];
    end

    assign lane = lanes[sel];

endmodule

// File: rtl/txr_engine.sv
module txr_engine
    import txr_pkg::*;
#(
    parameter  int ADDR_W = 16,
    localparam int WA_W   = ADDR_W - 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [WA_W-1:0] ring_base,
    input  logic            tx_run,
    input  logic            poll_wr,
    input  logic [31:0]     poll_data,
    output logic            mem_req,
    output logic            mem_we,
    output logic [WA_W-1:0] mem_addr,
    output logic [31:0]     mem_wdata,
    input  logic [31:0]     mem_rdata,
    output logic            out_valid,
    output logic [7:0]      out_data,
    output logic            out_first,
    output logic            out_last,
    output logic            idle
);

    localparam int WORD_W = 32;
    localparam int LANE_W = 8;
    localparam int LANES  = WORD_W / LANE_W;
    localparam int SEL_W  = $clog2(LANES);

    typedef struct packed {
        txr_state_e        st;
        logic [WA_W-1:0]   cur;
        logic [WA_W-1:0]   bptr;
        txr_ctrl_t         ctrl;
        logic [LEN_W-1:0]  left;
        logic [WORD_W-1:0] word;
        logic [SEL_W-1:0]  lane;
        logic              first;
        logic              pend;
    } regs_t;

    regs_t r_q, r_d;

    txr_ctrl_t       ctrl_raw;
    logic            len_ok;
    logic [31:0]     wb_status;
    logic [WA_W-1:0] next_desc;
    logic [7:0]      lane_byte;
    logic            poll_hit;

    assign ctrl_raw.eor       = mem_rdata[EOR_BIT];
    assign ctrl_raw.last_seg  = mem_rdata[LAST_BIT];
    assign ctrl_raw.first_seg = mem_rdata[FIRST_BIT];
    assign ctrl_raw.setup     = mem_rdata[SETUP_BIT];
    assign ctrl_raw.len       = mem_rdata[LEN_W-1:0];

    txr_ctrl_decode u_dec (
        .ctrl      (r_q.ctrl),
        .len_ok    (len_ok),
        .wb_status (wb_status)
    );

    txr_next_addr #(.WA_W(WA_W)) u_nxt (
        .cur  (r_q.cur),
        .base (ring_base),
        .eor  (r_q.ctrl.eor),
        .nxt  (next_desc)
    );

    txr_lane_mux #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_lane (
        .word (r_q.word),
        .sel  (r_q.lane),
        .lane (lane_byte)
    );

    assign poll_hit = poll_wr && (poll_data == POLL_CODE);

    always_comb begin
        r_d       = r_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = r_q.cur;
        mem_wdata = wb_status;
        out_valid = 1'b0;
        out_data  = lane_byte;
        out_first = 1'b0;
        out_last  = 1'b0;
        idle      = (r_q.st == S_STOP) || (r_q.st == S_SUSP);

        if (!idle) begin
            r_d.pend = r_q.pend | poll_hit;
        end

        unique case (r_q.st)
            S_STOP: begin
                r_d.cur  = ring_base;
                r_d.pend = 1'b0;
                if (tx_run) begin
                    r_d.st = S_SUSP;
                end
            end
            S_SUSP: begin
                r_d.pend = 1'b0;
                if (!tx_run) begin
                    r_d.st = S_STOP;
                end else if (poll_hit) begin
                    r_d.st = S_SREQ;
                end
            end
            S_SREQ: begin
                mem_req  = 1'b1;
                r_d.pend = poll_hit;
                r_d.st   = S_SCAP;
            end
            S_SCAP: begin
                if (mem_rdata[OWN_BIT]) begin
                    r_d.st = S_CREQ;
                end else if (r_q.pend || poll_hit) begin
                    r_d.st = S_SREQ;
                end else if (tx_run) begin
                    r_d.st = S_SUSP;
                end else begin
                    r_d.st = S_STOP;
                end
            end
            S_CREQ: begin
                mem_req  = 1'b1;
                mem_addr = r_q.cur + WA_W'(1);
                r_d.st   = S_CCAP;
            end
            S_CCAP: begin
                r_d.ctrl = ctrl_raw;
                r_d.st   = S_BREQ;
            end
            S_BREQ: begin
                mem_req  = 1'b1;
                mem_addr = r_q.cur + WA_W'(2);
                r_d.st   = S_BCAP;
            end
            S_BCAP: begin
                r_d.bptr  = mem_rdata[ADDR_W-1:2];
                r_d.left  = r_q.ctrl.len;
                r_d.first = 1'b1;
                r_d.st    = len_ok ? S_DREQ : S_WB;
            end
            S_DREQ: begin
                mem_req  = 1'b1;
                mem_addr = r_q.bptr;
                r_d.st   = S_DCAP;
            end
            S_DCAP: begin
                r_d.word = mem_rdata;
                r_d.bptr = r_q.bptr + WA_W'(1);
                r_d.lane = '0;
                if (!r_q.ctrl.setup) begin
                    r_d.st = S_EMIT;
                end else if (r_q.left <= LEN_W'(LANES)) begin
                    r_d.left = '0;
                    r_d.st   = S_WB;
                end else begin
                    r_d.left = r_q.left - LEN_W'(LANES);
                    r_d.st   = S_DREQ;
                end
            end
            S_EMIT: begin
                out_valid = 1'b1;
                out_first = r_q.first && r_q.ctrl.first_seg;
                out_last  = (r_q.left == LEN_W'(1)) && r_q.ctrl.last_seg;
                r_d.first = 1'b0;
                r_d.left  = r_q.left - LEN_W'(1);
                r_d.lane  = r_q.lane + SEL_W'(1);
                if (r_q.left == LEN_W'(1)) begin
                    r_d.st = S_WB;
                end else if (r_q.lane == SEL_W'(LANES - 1)) begin
                    r_d.st = S_DREQ;
                end
            end
            S_WB: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = r_q.cur;
                r_d.cur  = next_desc;
                r_d.st   = tx_run ? S_SREQ : S_STOP;
            end
            default: r_d.st = S_STOP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= S_STOP;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/txr_engine_chk.sv
module txr_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tx_run,
    input logic        poll_wr,
    input logic [31:0] poll_data,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_wdata,
    input logic        out_valid,
    input logic        out_first,
    input logic        out_last,
    input logic        idle
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (!mem_req && !out_valid)); // R1

    AST_WAKE_BY_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(idle) |-> $past(poll_wr && (poll_data == 32'd1) && tx_run)); // R2

    AST_WB_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> !mem_wdata[31]); // R5

    AST_FIRST_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        out_first |-> out_valid); // R4

    AST_LAST_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid); // R4

    AST_EMIT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !mem_req); // R4

    AST_WE_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req); // R5

endmodule

bind txr_engine txr_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_run    (tx_run),
    .poll_wr   (poll_wr),
    .poll_data (poll_data),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .out_valid (out_valid),
    .out_first (out_first),
    .out_last  (out_last),
    .idle      (idle)
);

// File: tb/sim_txr_engine.sv
`timescale 1ns/1ps
module sim_txr_engine;

    localparam int ADDR_W = 16;
    localparam int WA_W   = ADDR_W - 2;
    localparam int BASE   = 64;
    localparam logic [31:0] OWN = 32'h8000_0000;
    localparam logic [31:0] LSB = 32'h4000_0000;
    localparam logic [31:0] FSB = 32'h2000_0000;
    localparam logic [31:0] SET = 32'h0800_0000;
    localparam logic [31:0] EOR = 32'h0200_0000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [WA_W-1:0] ring_base = WA_W'(BASE);
    logic            tx_run = 1'b0;
    logic            poll_wr = 1'b0;
    logic [31:0]     poll_data = '0;
    logic            mem_req, mem_we;
    logic [WA_W-1:0] mem_addr;
    logic [31:0]     mem_wdata;
    logic [31:0]     mem_rdata = '0;
    logic            out_valid, out_first, out_last, idle;
    logic [7:0]      out_data;

    logic [31:0] mem [1024];
    logic        tb_we = 1'b0;
    logic [9:0]  tb_waddr = '0;
    logic [31:0] tb_wdata = '0;

    logic        clr = 1'b0;
    int          cap_n, rd_n, wr_n;
    int          last_rd;
    logic [7:0]  cap_d [256];
    logic        cap_f [256];
    logic        cap_l [256];

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    txr_engine #(.ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .tx_run(tx_run),
        .poll_wr(poll_wr), .poll_data(poll_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .out_data(out_data), .out_first(out_first),
        .out_last(out_last), .idle(idle)
    );

    always @(posedge clk) begin
        if (tb_we) begin
            mem[tb_waddr] <= tb_wdata;
        end else if (mem_req && mem_we) begin
            mem[mem_addr[9:0]] <= mem_wdata;
        end
        if (mem_req && !mem_we) begin
            mem_rdata <= mem[mem_addr[9:0]];
        end
    end

    always @(negedge clk) begin
        if (clr) begin
            cap_n = 0; rd_n = 0; wr_n = 0; last_rd = -1;
        end else begin
            if (out_valid && cap_n < 256) begin
                cap_d[cap_n] = out_data;
                cap_f[cap_n] = out_first;
                cap_l[cap_n] = out_last;
                cap_n++;
            end
            if (mem_req && !mem_we) begin
                rd_n++;
                last_rd = int'(mem_addr);
            end
            if (mem_req && mem_we) wr_n++;
        end
    end

    function automatic logic [7:0] pat(int a);
        return 8'((a * 13 + 7) & 255);
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic put_word(int a, logic [31:0] d);
        @(negedge clk);
        tb_we = 1'b1; tb_waddr = 10'(a); tb_wdata = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic set_desc(int i, logic [31:0] st, logic [31:0] ctl, int baddr);
        put_word(BASE + 4*i, st);
        put_word(BASE + 4*i + 1, ctl);
        put_word(BASE + 4*i + 2, 32'(baddr));
        put_word(BASE + 4*i + 3, 32'h0);
    endtask

    task automatic clear_mon();
        @(posedge clk); clr = 1'b1;
        @(posedge clk); clr = 1'b0;
    endtask

    task automatic poll(logic [31:0] v);
        @(negedge clk); poll_wr = 1'b1; poll_data = v;
        @(negedge clk); poll_wr = 1'b0; poll_data = '0;
    endtask

    task automatic wait_done();
        int t;
        t = 0;
        while (idle && t < 20) begin @(negedge clk); t++; end
        t = 0;
        while (!idle && t < 20000) begin @(negedge clk); t++; end
    endtask

    task automatic restart();
        @(negedge clk); tx_run = 1'b0;
        repeat (3) @(negedge clk);
        tx_run = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic chk_bytes(int from, int baddr, int n, string req);
        int bad;
        bad = 0;
        for (int k = 0; k < n; k++) begin
            if (cap_d[from + k] !== pat(baddr + k)) bad++;
        end
        chk(bad == 0, req, "byte mismatches", bad, 0);
    endtask

    task automatic t_reset();
        chk(idle === 1'b1, "R1", "idle after reset", idle, 1);
        chk(mem_req === 1'b0, "R1", "mem_req after reset", mem_req, 0);
        chk(out_valid === 1'b0, "R1", "out_valid after reset", out_valid, 0);
    endtask

    task automatic t_poll_filter();
        set_desc(0, OWN, FSB | LSB | 32'd4, 32'h400);
        set_desc(1, 32'h0, 32'h0, 0);
        clear_mon();
        poll(32'd1);
        repeat (10) @(negedge clk);
        chk(rd_n == 0, "R2", "reads on poll with run low", rd_n, 0);
        tx_run = 1'b1;
        repeat (3) @(negedge clk);
        poll(32'd2);
        repeat (10) @(negedge clk);
        chk(rd_n == 0, "R2", "reads on poll value 2", rd_n, 0);
        chk(idle === 1'b1, "R2", "idle after wrong poll", idle, 1);
        poll(32'd1);
        wait_done();
        chk(cap_n == 4, "R2", "bytes after valid poll", cap_n, 4);
    endtask

    task automatic t_not_owned();
        restart();
        set_desc(0, 32'h0, FSB | LSB | 32'd4, 32'h400);
        clear_mon();
        poll(32'd1);
        wait_done();
        chk(rd_n == 1, "R3", "reads on unowned", rd_n, 1);
        chk(wr_n == 0, "R3", "writes on unowned", wr_n, 0);
        chk(cap_n == 0, "R3", "bytes on unowned", cap_n, 0);
        chk(mem[BASE] == 32'h0, "R3", "status untouched", mem[BASE], 0);
    endtask

    task automatic t_single();
        restart();
        set_desc(0, OWN, FSB | LSB | 32'd6, 32'h400);
        set_desc(1, 32'h0, 32'h0, 0);
        clear_mon();
        poll(32'd1);
        wait_done();
        chk(cap_n == 6, "R4", "byte count", cap_n, 6);
        chk_bytes(0, 32'h400, 6, "R4");
        chk(cap_f[0] == 1'b1 && cap_f[1] == 1'b0, "R4", "first flag", {cap_f[0], cap_f[1]}, 2);
        chk(cap_l[5] == 1'b1 && cap_l[4] == 1'b0, "R4", "last flag", {cap_l[5], cap_l[4]}, 2);
        chk(mem[BASE] == 32'h0, "R5", "status written back", mem[BASE], 0);
        chk(last_rd == BASE + 4, "R8", "next descriptor address", last_rd, BASE + 4);
    endtask

    task automatic t_ring();
        int nf, nl;
        restart();
        set_desc(0, OWN, FSB | 32'd5, 32'h410);
        set_desc(1, OWN, LSB | 32'd3, 32'h422);
        set_desc(2, OWN, EOR | FSB | LSB | 32'd9, 32'h430);
        set_desc(3, OWN, FSB | LSB | 32'd1, 32'h440);
        clear_mon();
        poll(32'd1);
        wait_done();
        chk(cap_n == 17, "R8", "ring byte count", cap_n, 17);
        chk_bytes(0, 32'h410, 5, "R8");
        chk_bytes(5, 32'h420, 3, "R4");
        chk_bytes(8, 32'h430, 9, "R8");
        nf = 0; nl = 0;
        for (int k = 0; k < 17; k++) begin
            nf += int'(cap_f[k]);
            nl += int'(cap_l[k]);
        end
        chk(nf == 2 && cap_f[0] && cap_f[8], "R4", "first flags over ring", nf, 2);
        chk(nl == 2 && cap_l[7] && cap_l[16], "R4", "last flags over ring", nl, 2);
        chk(last_rd == BASE, "R8", "wrap to base", last_rd, BASE);
        chk(mem[BASE + 12] == OWN, "R8", "desc3 skipped", mem[BASE + 12], OWN);
        chk(mem[BASE + 8] == 32'h0, "R5", "desc2 status", mem[BASE + 8], 0);
    endtask

    task automatic t_zero_len();
        restart();
        set_desc(0, OWN, FSB | LSB, 32'h400);
        set_desc(1, 32'h0, 32'h0, 0);
        clear_mon();
        poll(32'd1);
        wait_done();
        chk(mem[BASE] == 32'h0000_8000, "R6", "error status", mem[BASE], 32'h8000);
        chk(cap_n == 0, "R6", "bytes on zero length", cap_n, 0);
        chk(rd_n == 4, "R6", "reads on zero length", rd_n, 4);
    endtask

    task automatic t_setup();
        restart();
        set_desc(0, OWN, SET | 32'd192, 32'h500);
        set_desc(1, OWN, SET | 32'd100, 32'h600);
        set_desc(2, 32'h0, 32'h0, 0);
        clear_mon();
        poll(32'd1);
        wait_done();
        chk(cap_n == 0, "R7", "setup bytes out", cap_n, 0);
        chk(mem[BASE] == 32'h7FFF_FFFF, "R7", "setup ok status", mem[BASE], 32'h7FFFFFFF);
        chk(mem[BASE + 4] == 32'h0000_8000, "R7", "setup bad length status", mem[BASE + 4], 32'h8000);
        chk(rd_n == 55, "R7", "setup reads", rd_n, 55);
    endtask

    task automatic t_stop();
        restart();
        set_desc(0, OWN, FSB | LSB | 32'd40, 32'h480);
        set_desc(1, OWN, FSB | LSB | 32'd4, 32'h4C0);
        set_desc(2, 32'h0, 32'h0, 0);
        clear_mon();
        poll(32'd1);
        repeat (4) @(negedge clk);
        tx_run = 1'b0;
        wait_done();
        chk(cap_n == 40, "R9", "frame finished after stop", cap_n, 40);
        chk_bytes(0, 32'h480, 40, "R9");
        chk(mem[BASE + 4] == OWN, "R9", "next desc untouched", mem[BASE + 4], OWN);
        set_desc(0, OWN, FSB | LSB | 32'd4, 32'h4E0);
        clear_mon();
        tx_run = 1'b1;
        repeat (3) @(negedge clk);
        poll(32'd1);
        wait_done();
        chk(cap_n == 8, "R9", "bytes after restart", cap_n, 8);
        chk_bytes(0, 32'h4E0, 4, "R9");
        chk_bytes(4, 32'h4C0, 4, "R9");
    endtask

    task automatic t_race();
        int t;
        restart();
        set_desc(0, 32'h0, FSB | LSB | 32'd4, 32'h440);
        set_desc(1, 32'h0, 32'h0, 0);
        clear_mon();
        @(negedge clk); poll_wr = 1'b1; poll_data = 32'd1;
        @(negedge clk); poll_wr = 1'b0; poll_data = '0;
        t = 0;
        while (!(mem_req && !mem_we) && t < 20) begin @(negedge clk); t++; end
        @(negedge clk);
        poll_wr = 1'b1; poll_data = 32'd1;
        tb_we = 1'b1; tb_waddr = 10'(BASE); tb_wdata = OWN;
        @(negedge clk);
        poll_wr = 1'b0; poll_data = '0; tb_we = 1'b0;
        wait_done();
        chk(cap_n == 4, "R10", "frame sent after racing poll", cap_n, 4);
        chk_bytes(0, 32'h440, 4, "R10");
        chk(mem[BASE] == 32'h0, "R10", "status after racing poll", mem[BASE], 0);
    endtask

    initial begin
        bit timeout;
        timeout = 1'b0;
        for (int w = 256; w < 1024; w++) begin
            mem[w] = {pat(4*w + 3), pat(4*w + 2), pat(4*w + 1), pat(4*w)};
        end
        for (int w = 0; w < 256; w++) mem[w] = 32'h0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        fork
            begin
                t_reset();
                t_poll_filter();
                t_not_owned();
                t_single();
                t_ring();
                t_zero_len();
                t_setup();
                t_stop();
                t_race();
            end
            begin
                repeat (150000) @(posedge clk);
                timeout = 1'b1;
            end
        join_any
        disable fork;
        if (timeout) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog all-requirements actual=hung expected=complete");
        end
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule